// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in front of a sector program controller. It decides, for each load period, whether the sector program that follows may change the array. It watches the decoded byte-load events coming from the neighbouring bus-timing logic. Each event carries an address and a data byte. The block matches the first loads of every period against fixed command sequences. Because the commands arrive through the same load events as ordinary data, they obey the same byte-load timing, including the inter-byte window. The neighbour closes the period by raising `period_end` once that window expires.

The block keeps a protection flag that no reset clears. The flag starts out off. The three-command unlock sequence turns it on. A six-command disable sequence turns it off again. While the flag is on, a period that did not open with the unlock sequence is still granted a program cycle. That cycle runs the internal write timer but writes nothing (a dummy grant). The block drives no array, buffer or bus-timing logic of its own.

Top module: `swp_sequencer`

## Requirements
- R1: Before any command has ever been recognised, `prot_on` reads 0 and neither grant output is high.
- R2: When the first three loads of a period are (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), `prot_on` is 1 in the cycle after the third load is accepted, and that period ends with a write grant.
- R3: When `prot_on` is 1 and a period does not open with the three-load unlock sequence, the period ends with `dummy_grant` high and `write_grant` low.
- R4: When `prot_on` is 1 and a period opens with the unlock sequence, the period ends with `write_grant` high, and `prot_on` stays 1.
- R5: When the first six loads of a period are (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x20), `prot_on` is 0 in the cycle after the sixth load, and the period ends with a write grant.
- R6: Asserting `rst` never changes `prot_on`, whichever value it holds.
- R7: A load whose address or data differs from the expected step of a partial sequence stops all command matching for the rest of that period. A correct sequence sent later in the same period is not recognised.
- R8: Each rising `period_end` produces, in the following cycle only, a one-cycle pulse on exactly one of `write_grant` and `dummy_grant`. Neither grant is high at any other time.
- R9: When `prot_on` is 0, any period ends with `write_grant`, whether or not it carries commands.
- R10: Asserting `rst` discards a partial command sequence. Matching restarts from the first step afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not touch the protection flag |
| load_valid | input | 1 | One-cycle pulse per accepted byte load |
| load_addr | input | AW (16) | Address of the byte load |
| load_data | input | DW (8) | Data of the byte load |
| period_end | input | 1 | One-cycle pulse when the load window has expired |
| prot_on | output | 1 | Protection flag |
| write_grant | output | 1 | Pulse: the program cycle may write the loaded bytes |
| dummy_grant | output | 1 | Pulse: run the program timer but write nothing |

## Verification
The third command byte is swept over all 256 values while unprotected. Only 0xA0 may raise the flag, while every value still earns a write grant; this separates the enable decode from the grant decision. Single-bit address errors on the second step, and data errors at each of the six disable positions, are applied while protected. They show that any wrong step drops matching and leaves a dummy grant rather than a partial unlock or disable. Data loaded ahead of a correct unlock, and a reset between steps, tell a matcher bound to the period start from one that merely scans for the pattern. Resets with the flag both set and clear show that the flag ignores reset.

// File: rtl/swp_pkg.sv
package swp_pkg;

    // Matcher state for one load period
    typedef enum logic [1:0] {
        M_ARMED = 2'd0,   // still following a command prefix
        M_OPEN  = 2'd1,   // unlock seen: later loads are plain data
        M_DEAD  = 2'd2    // no command can be recognised in this period
    } match_state_e;

    // Outcome of a closed load period
    typedef struct packed {
        logic write;
        logic dummy;
    } grant_t;

    localparam int SEQ_LEN    = 6;  // longest command (disable)
    localparam int UNLOCK_LEN = 3;  // unlock / enable command

    // Which command address a step expects: 0 = primary, 1 = secondary
    function automatic logic step_uses_secondary(input int unsigned step);
        return (step == 1) || (step == 4);
    endfunction

endpackage

// File: rtl/swp_cmd_matcher.sv
module swp_cmd_matcher
    import swp_pkg::*;
#(
    parameter int              AW        = 16,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   ADDR_PRI  = 16'h5555,
    parameter logic [AW-1:0]   ADDR_SEC  = 16'h2AAA,
    parameter logic [DW-1:0]   KEY_ONE   = 8'hAA,
    parameter logic [DW-1:0]   KEY_TWO   = 8'h55,
    parameter logic [DW-1:0]   CODE_EN   = 8'hA0,
    parameter logic [DW-1:0]   CODE_DIS1 = 8'h80,
    parameter logic [DW-1:0]   CODE_DIS2 = 8'h20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_valid,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          period_end,
    output logic          unlock_hit,
    output logic          disable_hit,
    output logic          seq_open
);
    localparam int STEP_W = $clog2(SEQ_LEN);
    localparam logic [STEP_W-1:0] EN_STEP   = STEP_W'(UNLOCK_LEN - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    match_state_e      state_q;
    logic [STEP_W-1:0] step_q;
    logic [AW-1:0]     exp_addr;
    logic [DW-1:0]     exp_data;
    logic              take, step_ok, en_ok;

    // Expected address and data for the current step
    always_comb begin
        exp_addr = step_uses_secondary(int'(step_q)) ? ADDR_SEC : ADDR_PRI;
        unique case (step_q)
            STEP_W'(0): exp_data = KEY_ONE;
            STEP_W'(1): exp_data = KEY_TWO;
            STEP_W'(2): exp_data = CODE_DIS1;
            STEP_W'(3): exp_data = KEY_ONE;
            STEP_W'(4): exp_data = KEY_TWO;
            default:    exp_data = CODE_DIS2;
        endcase
    end

    assign take    = load_valid && !period_end && !rst && (state_q == M_ARMED);
    assign step_ok = (load_addr == exp_addr) && (load_data == exp_data);
    assign en_ok   = (step_q == EN_STEP) && (load_addr == ADDR_PRI) && (load_data == CODE_EN);

    assign unlock_hit  = take && en_ok;
    assign disable_hit = take && !en_ok && step_ok && (step_q == LAST_STEP);
    assign seq_open    = (state_q == M_OPEN);

    always_ff @(posedge clk) begin
        if (rst || period_end) begin
            state_q <= M_ARMED;
            step_q  <= '0;
        end else if (take) begin
            if (en_ok) begin
                state_q <= M_OPEN;
            end else if (step_ok && step_q != LAST_STEP) begin
                step_q <= step_q + 1'b1;
            end else begin
                state_q <= M_DEAD;
                step_q  <= '0;
            end
        end
    end

    // R7
    dead_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_DEAD && !period_end) |=> (state_q == M_DEAD));

    // R10
    rst_rearms_chk: assert property (@(posedge clk)
        rst |=> (state_q == M_ARMED && step_q == '0));

endmodule

// File: rtl/swp_prot_flag.sv
module swp_prot_flag #(
    parameter bit INIT_ON = 1'b0
) (
    input  logic clk,
    input  logic set_hit,
    input  logic clear_hit,
    output logic prot_on
);
    // Non-volatile behaviour: initial value only, no reset path
    logic prot_q = INIT_ON;

    always_ff @(posedge clk) begin
        if (set_hit)
            prot_q <= 1'b1;
        else if (clear_hit)
            prot_q <= 1'b0;
    end

    assign prot_on = prot_q;

endmodule

// File: rtl/swp_period_judge.sv
module swp_period_judge
    import swp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   period_end,
    input  logic   seq_open,
    input  logic   prot_on,
    output grant_t grant
);
    grant_t grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else begin
            grant_q.write <= period_end && (!prot_on || seq_open);
            grant_q.dummy <= period_end && prot_on && !seq_open;
        end
    end

    assign grant = grant_q;

    // R8
    grant_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_q.write || grant_q.dummy) |-> $past(period_end));

    // R8
    grant_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $past(period_end) |-> $onehot({grant_q.write, grant_q.dummy}));

    // R3
    dummy_needs_prot_chk: assert property (@(posedge clk) disable iff (rst)
        grant_q.dummy |-> prot_on);

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
    import swp_pkg::*;
#(
    parameter int              AW        = 16,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   ADDR_PRI  = 16'h5555,
    parameter logic [AW-1:0]   ADDR_SEC  = 16'h2AAA,
    parameter logic [DW-1:0]   KEY_ONE   = 8'hAA,
    parameter logic [DW-1:0]   KEY_TWO   = 8'h55,
    parameter logic [DW-1:0]   CODE_EN   = 8'hA0,
    parameter logic [DW-1:0]   CODE_DIS1 = 8'h80,
    parameter logic [DW-1:0]   CODE_DIS2 = 8'h20,
    parameter bit              INIT_ON   = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_valid,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          period_end,
    output logic          prot_on,
    output logic          write_grant,
    output logic          dummy_grant
);
    logic   unlock_hit, disable_hit, seq_open;
    grant_t grant;

    swp_cmd_matcher #(
        .AW(AW), .DW(DW), .ADDR_PRI(ADDR_PRI), .ADDR_SEC(ADDR_SEC),
        .KEY_ONE(KEY_ONE), .KEY_TWO(KEY_TWO), .CODE_EN(CODE_EN),
        .CODE_DIS1(CODE_DIS1), .CODE_DIS2(CODE_DIS2)
    ) matcher_i (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_addr(load_addr),
        .load_data(load_data), .period_end(period_end),
        .unlock_hit(unlock_hit), .disable_hit(disable_hit), .seq_open(seq_open)
    );

    swp_prot_flag #(.INIT_ON(INIT_ON)) flag_i (
        .clk(clk), .set_hit(unlock_hit), .clear_hit(disable_hit), .prot_on(prot_on)
    );

    swp_period_judge judge_i (
        .clk(clk), .rst(rst), .period_end(period_end), .seq_open(seq_open),
        .prot_on(prot_on), .grant(grant)
    );

    assign write_grant = grant.write;
    assign dummy_grant = grant.dummy;

    // R2
    prot_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> $past(unlock_hit));

    // R5
    prot_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_on) |-> $past(disable_hit));

endmodule

// File: tb/swp_sequencer_tb.sv
module swp_sequencer_tb_top;
    localparam logic [15:0] PA = 16'h5555;
    localparam logic [15:0] SA = 16'h2AAA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_valid = 1'b0;
    logic [15:0] load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        period_end = 1'b0;
    logic        prot_on, write_grant, dummy_grant;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    swp_sequencer dut_i (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_addr(load_addr),
        .load_data(load_data), .period_end(period_end), .prot_on(prot_on),
        .write_grant(write_grant), .dummy_grant(dummy_grant)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        load_valid = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    // Close the period; check grant pulse then its return to zero (R8)
    task automatic close_period(input bit exp_write, input string tag);
        @(negedge clk);
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
        chk(write_grant == exp_write && dummy_grant == !exp_write, tag,
            {write_grant, dummy_grant}, {exp_write, !exp_write});
        @(negedge clk);
        chk(!write_grant && !dummy_grant, "R8 single pulse", {write_grant, dummy_grant}, 0);
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_unlock();
        load(PA, 8'hAA); load(SA, 8'h55); load(PA, 8'hA0);
    endtask

    task automatic send_disable();
        load(PA, 8'hAA); load(SA, 8'h55); load(PA, 8'h80);
        load(PA, 8'hAA); load(SA, 8'h55); load(PA, 8'h20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: initial state
        chk(prot_on == 1'b0, "R1 prot after reset", prot_on, 0);
        chk(!write_grant && !dummy_grant, "R1 grants idle", {write_grant, dummy_grant}, 0);

        // R9: unprotected plain period writes
        load(16'h1234, 8'h11);
        close_period(1'b1, "R9 plain period");

        // R2/R9: third byte sweep while unprotected
        for (int d = 0; d < 256; d++) begin
            load(PA, 8'hAA); load(SA, 8'h55); load(PA, 8'(d));
            chk(prot_on == (d == 8'hA0), "R2 enable decode", prot_on, (d == 8'hA0));
            close_period(1'b1, "R9 sweep grant");
            if (d == 8'hA0) begin
                send_disable();
                chk(prot_on == 1'b0, "R5 disable clears", prot_on, 0);
                close_period(1'b1, "R5 disable period");
            end
        end

        // R2: enable and keep
        send_unlock();
        chk(prot_on == 1'b1, "R2 enable sets", prot_on, 1);
        load(16'h0100, 8'h42);
        close_period(1'b1, "R2 enable period writes");

        // R3: protected plain period
        load(16'h0100, 8'h42);
        close_period(1'b0, "R3 blocked period");
        chk(prot_on == 1'b1, "R3 prot stays", prot_on, 1);

        // R6: reset while protected
        pulse_rst();
        chk(prot_on == 1'b1, "R6 reset keeps on", prot_on, 1);
        load(16'h0200, 8'h01);
        close_period(1'b0, "R6 blocked after reset");

        // R4: unlock then data
        send_unlock();
        load(16'h0300, 8'h77);
        chk(prot_on == 1'b1, "R4 prot stays on", prot_on, 1);
        close_period(1'b1, "R4 unlocked write");

        // R7: wrong data at each disable position
        for (int p = 0; p < 6; p++) begin
            logic [15:0] aa [6];
            logic [7:0]  dd [6];
            aa = '{PA, SA, PA, PA, SA, PA};
            dd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
            for (int k = 0; k < 6; k++)
                load(aa[k], (k == p) ? (dd[k] ^ 8'h01) : dd[k]);
            chk(prot_on == 1'b1, "R7 corrupt disable ignored", prot_on, 1);
            close_period(1'b0, "R7 corrupt disable blocked");
        end

        // R7: wrong address bit on second step
        for (int b = 0; b < 16; b++) begin
            load(PA, 8'hAA); load(SA ^ (16'h1 << b), 8'h55); load(PA, 8'hA0);
            close_period(1'b0, "R7 bad address blocked");
        end

        // R7: unlock after a data byte is not recognised
        load(16'h0400, 8'h99);
        send_unlock();
        close_period(1'b0, "R7 late unlock blocked");

        // R10: reset in the middle of a sequence
        load(PA, 8'hAA); load(SA, 8'h55);
        pulse_rst();
        chk(!write_grant && !dummy_grant, "R10 grants cleared", {write_grant, dummy_grant}, 0);
        load(PA, 8'hA0);
        close_period(1'b0, "R10 sequence restarted");

        // R5/R6: disable then reset keeps it off
        send_disable();
        chk(prot_on == 1'b0, "R5 disable clears", prot_on, 0);
        close_period(1'b1, "R5 disable period writes");
        pulse_rst();
        chk(prot_on == 1'b0, "R6 reset keeps off", prot_on, 0);
        load(16'h0500, 8'h05);
        close_period(1'b1, "R9 unprotected again");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule